// File: doc/BRIEF.md
# Receive Synchronizer with Bit and Error Counters

This block is the receive half of a bit-error-rate tester. A serial bit stream arrives one bit per cycle, qualified by a valid strobe. The block predicts each incoming bit with a local pseudo-random reference generator, flags every disagreement as a bit error and keeps a real-time loss-of-sync flag. While it has no lock, the reference is seeded from the received bits. After a run of consecutive correct predictions the block declares lock and lets the reference run free. A burst of errors inside a fixed window of bits drops the block back to hunting.

While locked, the block adds each received bit to an internal bit counter and each mismatch to an internal error counter. A rising edge on the count-load request copies both counters into snapshot registers and clears the counters in the same clock. The request is the OR of a pin and a control bit. Because the copy and the clear happen in one cycle, the two snapshot values always describe the same measurement interval.

Top module: `bert_rx_sync`

## Requirements
- R1: After reset `los` is 1, and `bit_snap` and `err_snap` are 0.
- R2: The reference predicts each bit as the XOR of the bits PRBS_LEN and PRBS_TAP positions back. The default is length 7 with tap 6, so a bit equals the bit 7 back XOR the bit 6 back. While hunting, the history is taken from the received bits. While locked, the history is extended with the predicted bits.
- R3: `los` goes to 0 in the cycle after the MATCH_N-th consecutive correctly predicted valid bit (default 32). A mismatch while hunting restarts the run from zero.
- R4: While locked, the valid bits are grouped into windows of WIN_BITS bits (default 64), counted from the moment of lock. A LOSS_ERRS-th mismatch inside one window (default 6) sets `los` to 1 in the next cycle. Fewer mismatches keep the lock.
- R5: Only valid bits received while `los` is 0 are counted. Each one adds 1 to the bit count, and each mismatched one also adds 1 to the error count.
- R6: A 0-to-1 transition of (`cnt_load_pin` OR `cnt_load_ctl`) copies the bit and error counts into `bit_snap` and `err_snap` and clears both counts. Holding the request high causes no further copy.
- R7: A counted bit that arrives in the same cycle as a load edge is counted into the new interval, so the count after the load starts at 1.
- R8: Both counts saturate at all ones (CNT_W bits) and do not wrap.
- R9: A cycle with `rx_valid` at 0 has no effect on the sync state, the reference or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received serial data bit |
| cnt_load_pin | input | 1 | Count-load request from a pin |
| cnt_load_ctl | input | 1 | Count-load request from a control bit |
| los | output | 1 | Loss of sync, 1 while hunting |
| bit_snap | output | CNT_W | Bit count latched at the last load edge |
| err_snap | output | CNT_W | Error count latched at the last load edge |

## Verification
A corrupted reference history or match-run count shows up on `los`. Lock is then taken too early, too late or never, and the error shows within one MATCH_N run of valid bits. A fault in the loss window shows on the first error burst: `los` rises at the wrong bit, or does not rise. Counter faults, such as a missed clear, a wrap, counting while hunting, or losing the bit that shares a cycle with the load, stay hidden inside the block until the next load edge. They then appear as a wrong pair of snapshot values. The bench therefore compares `los` after every bit and takes a snapshot after each phase.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
   typedef enum logic {
      SYNC_HUNT = 1'b0,
      SYNC_LOCK = 1'b1
   } sync_state_e;
endpackage

// File: rtl/bert_rx_refgen.sv
// Reference sequence generator: seeded from the line while hunting, free-running when locked.
module bert_rx_refgen #(
   parameter int PRBS_LEN = 7,
   parameter int PRBS_TAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic seed_mode,
   input  logic bit_in,
   output logic pred
);
   logic [PRBS_LEN-1:0] hist_q;

   assign pred = hist_q[PRBS_LEN-1] ^ hist_q[PRBS_TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (adv) begin
         hist_q <= {hist_q[PRBS_LEN-2:0], (seed_mode ? bit_in : pred)};
      end
   end
endmodule

// File: rtl/bert_rx_syncfsm.sv
// Hunt/lock state machine with match-run counter and error-burst window.
module bert_rx_syncfsm
   import bert_rx_pkg::*;
#(
   parameter int MATCH_N   = 32,
   parameter int LOSS_ERRS = 6,
   parameter int WIN_BITS  = 64,
   localparam int RUN_W    = $clog2(MATCH_N + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             mis,
   output logic             locked,
   output logic [RUN_W-1:0] run_cnt
);
   localparam int WIN_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
   localparam int ERR_W = $clog2(LOSS_ERRS + 1);

   sync_state_e      state_q;
   logic [RUN_W-1:0] run_q;
   logic [WIN_W-1:0] win_q;
   logic [ERR_W-1:0] werr_q;

   assign locked  = (state_q == SYNC_LOCK);
   assign run_cnt = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SYNC_HUNT;
         run_q   <= '0;
         win_q   <= '0;
         werr_q  <= '0;
      end else if (adv) begin
         if (state_q == SYNC_HUNT) begin
            if (mis) begin
               run_q <= '0;
            end else if (run_q == RUN_W'(MATCH_N - 1)) begin
               state_q <= SYNC_LOCK;
               run_q   <= '0;
               win_q   <= '0;
               werr_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            if (mis && (werr_q == ERR_W'(LOSS_ERRS - 1))) begin
               state_q <= SYNC_HUNT;
               run_q   <= '0;
            end else if (win_q == WIN_W'(WIN_BITS - 1)) begin
               win_q  <= '0;
               werr_q <= '0;
            end else begin
               win_q  <= win_q + 1'b1;
               werr_q <= werr_q + ERR_W'(mis);
            end
         end
      end
   end
endmodule

// File: rtl/bert_rx_cnt.sv
// Saturating event counter with atomic copy-to-snapshot and clear.
module bert_rx_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         snap <= '0;
      end else if (load) begin
         snap <= cnt;
         cnt  <= CNT_W'(inc);
      end else if (inc && (cnt != {CNT_W{1'b1}})) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
   parameter int PRBS_LEN  = 7,
   parameter int PRBS_TAP  = 6,
   parameter int MATCH_N   = 32,
   parameter int LOSS_ERRS = 6,
   parameter int WIN_BITS  = 64,
   parameter int CNT_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_bit,
   input  logic             cnt_load_pin,
   input  logic             cnt_load_ctl,
   output logic             los,
   output logic [CNT_W-1:0] bit_snap,
   output logic [CNT_W-1:0] err_snap
);
   localparam int RUN_W  = $clog2(MATCH_N + 1);
   localparam int N_CNTS = 2;

   if (PRBS_LEN < 2 || PRBS_TAP < 1 || PRBS_TAP >= PRBS_LEN) begin : g_bad_prbs
      $error("bert_rx_sync: PRBS_TAP must lie in 1..PRBS_LEN-1");
   end
   if (MATCH_N < 1 || LOSS_ERRS < 1 || LOSS_ERRS > WIN_BITS) begin : g_bad_sync
      $error("bert_rx_sync: need MATCH_N>=1 and 1<=LOSS_ERRS<=WIN_BITS");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("bert_rx_sync: CNT_W must be at least 2");
   end

   logic             pred, mis, locked;
   logic [RUN_W-1:0] run_cnt;
   logic             load_any, load_q, load_edge;
   logic             counted;
   logic             inc_a  [N_CNTS];
   logic [CNT_W-1:0] cnt_a  [N_CNTS];
   logic [CNT_W-1:0] snap_a [N_CNTS];
   logic [CNT_W-1:0] bit_cnt, err_cnt;

   assign mis       = rx_bit ^ pred;
   assign load_any  = cnt_load_pin | cnt_load_ctl;
   assign load_edge = load_any & ~load_q;
   assign counted   = rx_valid & locked;
   assign inc_a[0]  = counted;
   assign inc_a[1]  = counted & mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= load_any;
   end

   bert_rx_refgen #(.PRBS_LEN(PRBS_LEN), .PRBS_TAP(PRBS_TAP)) u_ref (
      .clk(clk), .rst_n(rst_n), .adv(rx_valid), .seed_mode(~locked),
      .bit_in(rx_bit), .pred(pred)
   );

   bert_rx_syncfsm #(.MATCH_N(MATCH_N), .LOSS_ERRS(LOSS_ERRS), .WIN_BITS(WIN_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .adv(rx_valid), .mis(mis),
      .locked(locked), .run_cnt(run_cnt)
   );

   for (genvar gi = 0; gi < N_CNTS; gi++) begin : g_cnt
      bert_rx_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_a[gi]), .load(load_edge),
         .cnt(cnt_a[gi]), .snap(snap_a[gi])
      );
   end

   assign bit_cnt  = cnt_a[0];
   assign err_cnt  = cnt_a[1];
   assign los      = ~locked;
   assign bit_snap = snap_a[0];
   assign err_snap = snap_a[1];
endmodule

// File: rtl/bert_rx_sync_chk.sv
module bert_rx_sync_chk #(
   parameter int MATCH_N = 32,
   parameter int CNT_W   = 32,
   localparam int RUN_W  = $clog2(MATCH_N + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             los,
   input logic             load_edge,
   input logic [RUN_W-1:0] run_cnt,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [CNT_W-1:0] err_cnt,
   input logic [CNT_W-1:0] bit_snap,
   input logic [CNT_W-1:0] err_snap
);
   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los) |-> $past(run_cnt) == RUN_W'(MATCH_N - 1)); // R3
   AST_NO_COUNT_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (los && !load_edge) |=> $stable(bit_cnt) && $stable(err_cnt)); // R5
   AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      err_snap <= bit_snap && err_cnt <= bit_cnt); // R5
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_edge |=> $stable(bit_snap) && $stable(err_snap)); // R6
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      load_edge |=> bit_snap == $past(bit_cnt) && err_snap == $past(err_cnt)); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt == {CNT_W{1'b1}} && !load_edge) |=> bit_cnt == {CNT_W{1'b1}}); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(los)); // R9
endmodule

bind bert_rx_sync bert_rx_sync_chk #(.MATCH_N(MATCH_N), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .los(los),
   .load_edge(load_edge), .run_cnt(run_cnt), .bit_cnt(bit_cnt),
   .err_cnt(err_cnt), .bit_snap(bit_snap), .err_snap(err_snap)
);

// File: tb/bert_rx_sync_tb.sv
module bert_rx_sync_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int CMAX       = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0, rx_bit = 1'b0, cnt_load_pin = 1'b0, cnt_load_ctl = 1'b0;
   logic los;
   logic [CNT_W-1:0] bit_snap, err_snap;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model state (from the requirements)
   logic [6:0] gen_s = 7'h7F;
   logic [6:0] m_hist = '0;
   bit m_lock = 1'b0, m_ldq = 1'b0;
   int m_run = 0, m_win = 0, m_werr = 0;
   int m_bc = 0, m_ec = 0, m_bs = 0, m_es = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bert_rx_sync #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
      .cnt_load_pin(cnt_load_pin), .cnt_load_ctl(cnt_load_ctl),
      .los(los), .bit_snap(bit_snap), .err_snap(err_snap)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_snap(input string tag);
      chk(tag, int'(bit_snap), m_bs);
      chk(tag, int'(err_snap), m_es);
   endtask

   // one cycle: drive at negedge, update model at posedge, compare los at next negedge
   task automatic step(input bit v, input bit flip, input bit lp, input bit lc, input string tag);
      bit b, pred, mis, edge_, inc_b, inc_e;
      b = gen_s[6] ^ gen_s[5] ^ flip;
      if (v) gen_s = {gen_s[5:0], gen_s[6] ^ gen_s[5]};
      rx_valid = v; rx_bit = b; cnt_load_pin = lp; cnt_load_ctl = lc;
      @(posedge clk);
      pred  = m_hist[6] ^ m_hist[5];
      mis   = (b != pred);
      edge_ = (lp | lc) & !m_ldq;
      m_ldq = lp | lc;
      inc_b = v && m_lock;
      inc_e = inc_b && mis;
      if (edge_) begin
         m_bs = m_bc; m_es = m_ec;
         m_bc = int'(inc_b); m_ec = int'(inc_e);
      end else begin
         if (inc_b && m_bc < CMAX) m_bc++;
         if (inc_e && m_ec < CMAX) m_ec++;
      end
      if (v) begin
         if (!m_lock) begin
            m_hist = {m_hist[5:0], b};
            if (mis) m_run = 0;
            else if (m_run == 31) begin m_lock = 1'b1; m_run = 0; m_win = 0; m_werr = 0; end
            else m_run++;
         end else begin
            m_hist = {m_hist[5:0], pred};
            if (mis && m_werr == 5) begin m_lock = 1'b0; m_run = 0; end
            else if (m_win == 63) begin m_win = 0; m_werr = 0; end
            else begin m_win++; m_werr += int'(mis); end
         end
      end
      @(negedge clk);
      chk(tag, int'(los), int'(!m_lock));
   endtask

   task automatic clean(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic snap_ctl(input string tag);
      step(1'b0, 1'b0, 1'b0, 1'b1, tag);
      step(1'b0, 1'b0, 1'b0, 1'b0, tag);
      chk_snap(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", int'(los), 1);
      chk("R1", int'(bit_snap), 0);
      chk("R1", int'(err_snap), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 acquisition from reset on a clean stream, R2 reference seeding
      clean(45, "R3");
      chk("R3", int'(los), 0);
      clean(40, "R2");
      snap_ctl("R2");
      chk("R2", int'(err_snap), 0);

      // R4 five errors inside a window keep the lock
      for (int i = 0; i < 60; i++) step(1'b1, (i % 12) == 3, 1'b0, 1'b0, "R4");
      chk("R4", int'(los), 0);
      // R6 snapshot from the pin
      step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
      chk_snap("R6");
      chk("R5", int'(err_snap), 5);
      chk("R5", int'(bit_snap), 60);

      // R7 bit in the load cycle goes to the new interval
      step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
      chk_snap("R7");
      clean(9, "R7");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
      snap_ctl("R7");
      chk("R7", int'(bit_snap), 10);

      // R6 held request: no second copy
      step(1'b1, 1'b0, 1'b1, 1'b0, "R6");
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R6");
      chk_snap("R6");
      chk("R6", int'(bit_snap), 0);
      step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
      snap_ctl("R6");
      chk("R6", int'(bit_snap), 11);

      // R9 invalid cycles have no effect, even with garbage data
      for (int i = 0; i < 20; i++) step(1'b0, (i % 2) == 0, 1'b0, 1'b0, "R9");
      chk("R9", int'(los), 0);
      snap_ctl("R9");
      chk("R9", int'(bit_snap), 0);

      // R4 error burst drops the lock
      clean(5, "R4");
      for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R4");
      chk("R4", int'(los), 1);
      // R5 nothing counted while hunting
      snap_ctl("R5");
      clean(20, "R5");
      snap_ctl("R5");
      chk("R5", int'(bit_snap), 0);

      // R3 mismatch during hunt restarts the run
      clean(10, "R3");
      step(1'b1, 1'b1, 1'b0, 1'b0, "R3");
      clean(30, "R3");
      chk("R3", int'(los), 1);
      clean(40, "R3");
      chk("R3", int'(los), 0);

      // R8 saturation
      snap_ctl("R8");
      clean(300, "R8");
      snap_ctl("R8");
      chk("R8", int'(bit_snap), CMAX);
      chk("R8", int'(err_snap), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule